// File: doc/BRIEF.md
# Block Transfer DMA Engine

This block is a single-channel bus master that copies a block of words between an I/O device and memory, so the processor never handles the data. Software sets up a transfer through four word-wide registers: the memory start address, the number of words, and a control word holding the direction, the bus mode and a device select. Writing the control word with its start bit set launches the transfer. The engine then asks for the system bus, moves one word per beat, steps the address up and the remaining count down, and raises a sticky interrupt when the count reaches zero.

Two bus modes can be chosen at run time. In burst mode the engine keeps its bus request high from the first grant until the last word has been stored, so the processor is locked out for the whole block. In cycle-steal mode the request is dropped for at least one cycle after every word, so the processor can use the bus between beats. The request has priority over the processor; an external arbiter turns it into a grant.

Memory and both device streams use valid/ready handshakes, and a beat completes in any cycle where valid and ready are both high. Once the engine raises valid on the memory port or the device output stream, it keeps valid, the address and the data steady until ready is seen. Either receiver may hold ready low for any number of cycles. The device input stream follows the same rule in the opposite direction, and the engine only raises its ready while it is waiting for a word.

Top module: `dmac_engine`

## Requirements
- R1: After reset the engine is idle: bus_req, irq, mem_valid, dev_in_ready and dev_out_valid are low, and the status register reads 0.
- R2: Register map on cfg_addr: 0 is control (bit 0 start, write-only; bit 1 direction, 0 means device to memory and 1 means memory to device; bit 2 mode, 0 burst and 1 cycle-steal; bits 11:8 device select), 1 is the memory word address, 2 is the remaining word count, and 3 is status (bit 0 busy, bit 1 interrupt). Control reads back direction, mode and device select in the same bit positions.
- R3: A start with a non-zero count raises bus_req, and bus_req stays high until bus_gnt arrives. mem_valid is high only while both bus_gnt and bus_req are high.
- R4: Device to memory: each word accepted on the device input stream is written to memory, in arrival order, at consecutive word addresses starting at the programmed address.
- R5: Memory to device: words read from consecutive memory addresses are presented in address order on the device output stream. dev_out_valid and dev_out_data stay steady until they are accepted.
- R6: Each completed word increments the address register by one and decrements the count register by one. At the end of the block the address register reads start plus length, and the count register reads 0.
- R7: In burst mode bus_req rises exactly once per block and stays high until the last word is stored.
- R8: In cycle-steal mode bus_req goes low for at least one cycle after every word, so it rises once per word in the block.
- R9: In the cycle after the last word completes, irq is high, bus_req is low and the busy status bit reads 0.
- R10: A start while the count is 0 sets irq in the next cycle and never asserts bus_req.
- R11: irq stays high until software writes status with bit 1 set. A status write with bit 1 clear has no effect on irq.
- R12: Writes to control, address or count while busy is high are ignored, including a start.
- R13: dev_sel drives the programmed device select for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt, sticky |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| dev_sel | output | DEVW | Selected device |
| mem_valid | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory access accepted |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, sampled on the read handshake |
| dev_in_valid | input | 1 | Device word available |
| dev_in_ready | output | 1 | Engine takes a device word |
| dev_in_data | input | DW | Device word |
| dev_out_valid | output | 1 | Word offered to the device |
| dev_out_ready | input | 1 | Device takes the word |
| dev_out_data | output | DW | Word to the device |

## Verification
The assertions inside the RTL check the properties that hold in every cycle. They check that memory is touched only under grant, that a pending request is held until granted, and that the device output word stays steady under back-pressure. They also check the single-step movement of address and count, the release of the bus after each stolen word against the holding of it in burst mode, the stickiness of the interrupt, and that registers are frozen while busy. Only the bench's scenarios can show the data itself arriving in order at the right addresses for each direction. The same goes for the number of bus requests per block in each mode, the final register contents, the interrupt timing after the last word, and the effect of writes made in the middle of a transfer.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_FETCH,
    ST_STORE,
    ST_GAP
  } mv_state_t;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_MADDR = 2'd1;
  localparam logic [1:0] RA_COUNT = 2'd2;
  localparam logic [1:0] RA_STAT  = 2'd3;

  localparam int CB_START  = 0;
  localparam int CB_DIR    = 1;
  localparam int CB_MODE   = 2;
  localparam int CB_DEV_LO = 8;

  localparam int SB_BUSY = 0;
  localparam int SB_IRQ  = 1;

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int DEVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [1:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            busy,
  input  logic            beat_done,
  input  logic            blk_done,
  output logic            go,
  output logic            dir,
  output logic            steal,
  output logic [DEVW-1:0] dev_sel,
  output logic [AW-1:0]   cur_addr,
  output logic            last,
  output logic            irq
);

  logic            dir_q, steal_q, irq_q;
  logic [DEVW-1:0] dev_q;
  logic [AW-1:0]   addr_q;
  logic [CW-1:0]   cnt_q;

  logic wr_ctrl, wr_maddr, wr_cnt, irq_clr, start_req, zero_start;
  logic unused_wdata;

  assign wr_ctrl    = cfg_wr && (cfg_addr == RA_CTRL)  && !busy;
  assign wr_maddr   = cfg_wr && (cfg_addr == RA_MADDR) && !busy;
  assign wr_cnt     = cfg_wr && (cfg_addr == RA_COUNT) && !busy;
  assign irq_clr    = cfg_wr && (cfg_addr == RA_STAT)  && cfg_wdata[SB_IRQ];
  assign start_req  = wr_ctrl && cfg_wdata[CB_START];
  assign go         = start_req && (cnt_q != '0);
  assign zero_start = start_req && (cnt_q == '0);
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      steal_q <= 1'b0;
      dev_q   <= '0;
    end else if (wr_ctrl) begin
      dir_q   <= cfg_wdata[CB_DIR];
      steal_q <= cfg_wdata[CB_MODE];
      dev_q   <= cfg_wdata[CB_DEV_LO +: DEVW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (beat_done) begin
      addr_q <= addr_q + AW'(1);
    end else if (wr_maddr) begin
      addr_q <= cfg_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (beat_done) begin
      cnt_q <= cnt_q - CW'(1);
    end else if (wr_cnt) begin
      cnt_q <= cfg_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (blk_done || zero_start) begin
      irq_q <= 1'b1;
    end else if (irq_clr) begin
      irq_q <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RA_CTRL: begin
        cfg_rdata[CB_DIR]              = dir_q;
        cfg_rdata[CB_MODE]             = steal_q;
        cfg_rdata[CB_DEV_LO +: DEVW]   = dev_q;
      end
      RA_MADDR: cfg_rdata[AW-1:0] = addr_q;
      RA_COUNT: cfg_rdata[CW-1:0] = cnt_q;
      default: begin
        cfg_rdata[SB_BUSY] = busy;
        cfg_rdata[SB_IRQ]  = irq_q;
      end
    endcase
  end

  assign dir      = dir_q;
  assign steal    = steal_q;
  assign dev_sel  = dev_q;
  assign cur_addr = addr_q;
  assign last     = (cnt_q == CW'(1));
  assign irq      = irq_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |=> cnt_q == $past(cnt_q) - CW'(1)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |=> addr_q == $past(addr_q) + AW'(1)); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr |=> irq_q); // R11
  AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> irq_q && !busy); // R10
  AST_FROZEN_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat_done |=> $stable(cnt_q) && $stable(addr_q)); // R12
  AST_FROZEN_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dir_q) && $stable(steal_q) && $stable(dev_q)); // R12

endmodule

// File: rtl/dmac_mover.sv
module dmac_mover
  import dmac_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          dir,
  input  logic          steal,
  input  logic          last,
  input  logic [AW-1:0] cur_addr,
  output logic          busy,
  output logic          beat_done,
  output logic          blk_done,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_in_valid,
  output logic          dev_in_ready,
  input  logic [DW-1:0] dev_in_data,
  output logic          dev_out_valid,
  input  logic          dev_out_ready,
  output logic [DW-1:0] dev_out_data
);

  mv_state_t     state_q, state_d;
  logic [DW-1:0] buf_q;
  logic          in_fetch, in_store, fetch_hs, store_hs;

  assign in_fetch = (state_q == ST_FETCH);
  assign in_store = (state_q == ST_STORE);

  // memory side only moves while the bus is ours
  assign mem_valid = bus_gnt && ((in_fetch && dir) || (in_store && !dir));
  assign mem_we    = in_store && !dir;
  assign mem_addr  = cur_addr;
  assign mem_wdata = buf_q;

  assign dev_in_ready  = in_fetch && !dir;
  assign dev_out_valid = in_store && dir;
  assign dev_out_data  = buf_q;

  assign fetch_hs = in_fetch && (dir ? (mem_valid && mem_ready)
                                     : (dev_in_valid && dev_in_ready));
  assign store_hs = in_store && (dir ? (dev_out_valid && dev_out_ready)
                                     : (mem_valid && mem_ready));

  assign beat_done = store_hs;
  assign blk_done  = store_hs && last;
  assign busy      = (state_q != ST_IDLE);
  assign bus_req   = (state_q == ST_ARB) || in_fetch || in_store;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (go) state_d = ST_ARB;
      ST_ARB:   if (bus_gnt) state_d = ST_FETCH;
      ST_FETCH: if (fetch_hs) state_d = ST_STORE;
      ST_STORE: begin
        if (store_hs) begin
          if (last)       state_d = ST_IDLE;
          else if (steal) state_d = ST_GAP;
          else            state_d = ST_FETCH;
        end
      end
      ST_GAP:   state_d = ST_ARB;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (fetch_hs) begin
      buf_q <= dir ? mem_rdata : dev_in_data;
    end
  end

  AST_MEM_UNDER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> bus_gnt && bus_req); // R3
  AST_REQ_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req); // R3
  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done && steal && !last |=> !bus_req); // R8
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done && !steal && !last |=> bus_req); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid && !dev_out_ready |=> dev_out_valid && $stable(dev_out_data)); // R5
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !bus_req && !busy); // R9

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int DEVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [1:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic            irq,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic [DEVW-1:0] dev_sel,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            dev_in_valid,
  output logic            dev_in_ready,
  input  logic [DW-1:0]   dev_in_data,
  output logic            dev_out_valid,
  input  logic            dev_out_ready,
  output logic [DW-1:0]   dev_out_data
);

  logic          go, dir, steal, last, busy, beat_done, blk_done;
  logic [AW-1:0] cur_addr;

  dmac_regs #(.AW(AW), .CW(CW), .DEVW(DEVW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .busy      (busy),
    .beat_done (beat_done),
    .blk_done  (blk_done),
    .go        (go),
    .dir       (dir),
    .steal     (steal),
    .dev_sel   (dev_sel),
    .cur_addr  (cur_addr),
    .last      (last),
    .irq       (irq)
  );

  dmac_mover #(.AW(AW), .DW(DW)) mover_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            (go),
    .dir           (dir),
    .steal         (steal),
    .last          (last),
    .cur_addr      (cur_addr),
    .busy          (busy),
    .beat_done     (beat_done),
    .blk_done      (blk_done),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .dev_in_valid  (dev_in_valid),
    .dev_in_ready  (dev_in_ready),
    .dev_in_data   (dev_in_data),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_out_data  (dev_out_data)
  );

endmodule

// File: tb/dmac_engine_tb.sv
`timescale 1ns/1ps
module dmac_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq, bus_req, mem_valid, mem_we, dev_in_ready, dev_out_valid;
  logic        bus_gnt = 1'b0, mem_ready = 1'b0, dev_in_valid = 1'b0, dev_out_ready = 1'b0;
  logic [3:0]  dev_sel;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, dev_out_data;
  logic [31:0] mem_rdata = '0, dev_in_data = '0;

  always #4 clk = ~clk;

  dmac_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .dev_sel(dev_sel),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data), .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data)
  );

  int tests = 0, fails = 0;

  // reference model state
  logic [31:0] mem_m [int];
  logic [31:0] src_q [$];
  logic [31:0] sent_q [$];
  int  cyc = 0, exp_addr = 0, exp_left = 0, rises = 0;
  int  gnt_lat = 0, gnt_wait = 0, stall_mod = 3;
  logic [3:0] exp_dev = '0;
  bit  running = 0, irq_due = 0, req_prev = 0, src_hold = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memval(input int a);
    if (mem_m.exists(a)) return mem_m[a];
    return (32'(a) * 32'h0100_0193) ^ 32'hC0DE_0000;
  endfunction

  // cycle-by-cycle bus, memory and device model, checked every clock
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!bus_req) begin gnt_wait = 0; bus_gnt = 1'b0; end
      else if (gnt_wait < gnt_lat) begin gnt_wait++; bus_gnt = 1'b0; end
      else bus_gnt = 1'b1;
      #1;
      if (bus_req && !req_prev) rises++;
      req_prev = bus_req;
      if (irq_due) begin
        chk(irq && !bus_req, "R9", "irq/req after last word", {irq, bus_req}, 2'b10);
        irq_due = 0;
        running = 0;
      end
      if (!running) chk(!bus_req && !mem_valid, "R10", "bus idle", {bus_req, mem_valid}, 0);
      if (mem_valid) chk(bus_gnt, "R3", "mem_valid without grant", bus_gnt, 1);
      // memory
      mem_ready = (cyc % stall_mod) != 0;
      if (mem_valid && mem_ready) begin
        chk(int'(mem_addr) == exp_addr, "R4", "memory address", mem_addr, exp_addr);
        chk(dev_sel == exp_dev, "R13", "device select", dev_sel, exp_dev);
        if (mem_we) begin
          logic [31:0] e;
          e = (sent_q.size() > 0) ? sent_q.pop_front() : 32'hxxxx_xxxx;
          chk(mem_wdata === e, "R4", "memory write data", mem_wdata, e);
          mem_m[int'(mem_addr)] = mem_wdata;
          exp_addr++;
          exp_left--;
          if (exp_left == 0) irq_due = 1;
        end else begin
          mem_rdata = memval(int'(mem_addr));
        end
      end
      // device source
      dev_in_valid = src_hold || (src_q.size() > 0 && (cyc % 3) != 0);
      if (dev_in_valid) dev_in_data = src_q[0];
      src_hold = dev_in_valid;
      if (dev_in_valid && dev_in_ready) begin
        sent_q.push_back(src_q.pop_front());
        src_hold = 0;
      end
      // device sink
      dev_out_ready = (cyc % 4) != 2;
      if (dev_out_valid && dev_out_ready) begin
        chk(dev_out_data == memval(exp_addr), "R5", "device output word",
            dev_out_data, memval(exp_addr));
        chk(dev_sel == exp_dev, "R13", "device select", dev_sel, exp_dev);
        exp_addr++;
        exp_left--;
        if (exp_left == 0) irq_due = 1;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #2;
    d = cfg_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input bit d, input bit s, input logic [3:0] dv);
    return (32'(dv) << 8) | (32'(s) << 2) | (32'(d) << 1) | 32'd1;
  endfunction

  task automatic run_block(input bit d, input bit s, input logic [3:0] dv,
                           input int addr, input int n, input int lat,
                           input int stall, input bit poke);
    logic [31:0] v;
    int t;
    exp_addr = addr; exp_left = n; exp_dev = dv; gnt_lat = lat; stall_mod = stall;
    if (!d) for (int k = 0; k < n; k++) src_q.push_back(32'hD000_0000 + 32'(addr) * 16 + 32'(k));
    wr(2'd1, 32'(addr));
    wr(2'd2, 32'(n));
    rises = 0;
    running = 1;
    wr(2'd0, ctrl_word(d, s, dv));
    if (poke) begin
      repeat (3) @(negedge clk);
      wr(2'd1, 32'h0000_7777);   // R12 ignored address write
      wr(2'd2, 32'd99);          // R12 ignored count write
      wr(2'd0, ctrl_word(!d, !s, 4'hF)); // R12 ignored start
    end
    t = 0;
    while (running && t < 5000) begin @(negedge clk); t++; end
    chk(!running, "R9", "block finished", running, 0);
    rd(2'd3, v);
    chk(v == 32'd2, "R9", "status after block", v, 2);
    rd(2'd1, v);
    chk(v == 32'(addr + n), "R6", "final address", v, addr + n);
    rd(2'd2, v);
    chk(v == 32'd0, "R6", "final count", v, 0);
    rd(2'd0, v);
    chk(v == ((32'(dv) << 8) | (32'(s) << 2) | (32'(d) << 1)), "R2", "control readback",
        v, (32'(dv) << 8) | (32'(s) << 2) | (32'(d) << 1));
    if (s) chk(rises == n, "R8", "requests per stolen block", rises, n);
    else   chk(rises == 1, "R7", "requests per burst block", rises, 1);
    chk(irq, "R11", "irq held after block", irq, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd3, v);
    chk(v == 0, "R1", "status after reset", v, 0);
    chk(!bus_req && !irq && !mem_valid && !dev_in_ready && !dev_out_valid,
        "R1", "outputs after reset",
        {bus_req, irq, mem_valid, dev_in_ready, dev_out_valid}, 0);

    // R4 R7 device to memory, burst
    run_block(1'b0, 1'b0, 4'd3, 32'h100, 6, 2, 3, 1'b0);

    // R11 clear rules
    wr(2'd3, 32'd0);
    chk(irq, "R11", "status write without bit 1", irq, 1);
    wr(2'd3, 32'd2);
    chk(!irq, "R11", "status write clears irq", irq, 0);

    // R5 R8 memory to device, cycle steal
    run_block(1'b1, 1'b1, 4'd9, 32'h200, 5, 1, 4, 1'b0);
    wr(2'd3, 32'd2);

    // R8 R12 device to memory, cycle steal, with writes while busy
    run_block(1'b0, 1'b1, 4'd5, 32'h300, 4, 3, 2, 1'b1);
    wr(2'd3, 32'd2);

    // R7 memory to device burst over the words written earlier
    run_block(1'b1, 1'b0, 4'd12, 32'h100, 7, 0, 5, 1'b0);
    wr(2'd3, 32'd2);
    chk(!irq, "R11", "irq cleared before zero start", irq, 0);

    // R10 zero-length start
    rises = 0;
    wr(2'd0, ctrl_word(1'b0, 1'b0, 4'd1));
    chk(irq, "R10", "irq after zero-count start", irq, 1);
    repeat (8) @(negedge clk);
    chk(rises == 0, "R10", "no request on zero count", rises, 0);
    rd(2'd3, v);
    chk(v == 32'd2, "R10", "status after zero start", v, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule